// File: doc/BRIEF.md
# EPP Host Cycle Controller

This block is the host end of an enhanced parallel port. A host issues register reads and writes over a small synchronous register bus. Accesses to the EPP address port or to any of the four EPP data ports are turned into interlocked strobe cycles on the parallel bus. The host access is held with a stall signal until the peripheral's wait line completes the handshake. Accesses to the plain data, status and control registers finish at once. When no EPP cycle is running, the data bus and the three control pins follow the control register, as in standard and bidirectional operation.

A watchdog guards every EPP cycle. If the handshake has not finished within a fixed time (10 us by default), the cycle is dropped, the host is released and a sticky timeout flag is set. Two control bits change how a cycle behaves. An active STROBE bit forces any EPP cycle into a write. A set direction bit turns an EPP write into a cycle that looks like a read, and no error is raised.

The cycle controller has six states. `ST_IDLE` waits for an EPP access. It goes to `ST_SETUP` when the host selects an EPP port while EPP mode is on. `ST_SETUP` waits for the synchronised wait line to go low, then goes to `ST_CMD`. If the watchdog expires first, it goes to `ST_ABORT`. `ST_CMD` drives the byte and nWRITE for one cycle and then goes to `ST_STRB`, or to `ST_ABORT` on expiry. `ST_STRB` holds the selected strobe low. It goes to `ST_DONE` when the wait line goes high, or to `ST_ABORT` on expiry. `ST_DONE` releases the strobe and completes the host access. `ST_ABORT` releases everything and completes the host access with the timeout result. Both `ST_DONE` and `ST_ABORT` return to `ST_IDLE` after one cycle.

Top module: `epp_host_ctrl`

## Requirements
- R1: After reset, n_write, n_datastb and n_addrstb are high and pd_oe is 1. The status register (offset 1) reads 00h and the control register (offset 2) reads 00h.
- R2: When no cycle is active, strobe_o, autofd_o and init_o equal control bits 0, 1 and 2. pd_out equals the data register (offset 0). pd_oe is the inverse of control bit 5 (direction, 1 = input).
- R3: A host write to offset 3 (address port) or to offsets 4 to 7 (data ports) is stalled. The block waits for nWAIT low, then drives the byte with pd_oe=1 and n_write low, and only then pulls n_addrstb (offset 3) or n_datastb (offsets 4 to 7) low. After nWAIT returns high, the strobe is released and the host access completes.
- R4: An EPP read leaves pd_oe=0 and n_write high during the strobe. It returns the pd_in byte that was present when nWAIT went high.
- R5: With control bit 0 (STROBE) set, any EPP cycle, including a host read, drives the data register byte with pd_oe=1 and n_write low.
- R6: With control bit 5 set and bit 0 clear, an EPP write runs as a read-style cycle (pd_oe=0, n_write high), and the status timeout bit stays 0.
- R7: If an EPP cycle has not completed 2000 clock cycles (10 us at 200 MHz) after it starts, it is aborted. Both strobes and n_write go high, the host access completes, a read returns FFh, and status bit 0 reads 1.
- R8: Status bit 0 stays set until the host writes the status register with bit 0 = 1. Writing 0 to that bit leaves it set.
- R9: While epp_en is 0, offsets 3 to 7 complete without stall, read FFh and produce no strobe.
- R10: n_datastb and n_addrstb are never low at the same time, and a strobe is only low while the host access is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| epp_en | input | 1 | EPP mode selected |
| hb_sel | input | 1 | Host access request, held until accepted |
| hb_wr | input | 1 | 1 = write, 0 = read |
| hb_addr | input | 3 | Register offset |
| hb_wdata | input | 8 | Write data |
| hb_rdata | output | 8 | Read data, valid when hb_sel and not hb_stall |
| hb_stall | output | 1 | Wait state for the current host access |
| pd_out | output | 8 | Parallel data driven outward |
| pd_in | input | 8 | Parallel data sampled from the bus |
| pd_oe | output | 1 | 1 = block drives the data bus |
| n_write | output | 1 | Cycle direction, low for write |
| n_datastb | output | 1 | Data strobe, active low |
| n_addrstb | output | 1 | Address strobe, active low |
| n_wait | input | 1 | Peripheral handshake, asynchronous |
| strobe_o | output | 1 | STROBE control level |
| autofd_o | output | 1 | AUTOFD control level |
| init_o | output | 1 | INIT control level |

## Verification
A state register that leaves `ST_IDLE` without an access, or that never leaves `ST_STRB`, shows at the ports within one handshake. The strobe falls while the host is not stalled, or the host stays stalled past the 2000-cycle window with no abort. A wrong latch of the cycle direction shows in the first strobe cycle as a wrong pd_oe or n_write level. A flag that fails to set or clear shows on the next status read. The scoreboard pairs every strobe edge and every completed read with an expected item, so a missing or extra cycle appears as soon as the queue runs out or falls behind.

// File: rtl/epp_pkg.sv
package epp_pkg;

    // host register offsets
    localparam logic [2:0] OFS_DATA   = 3'd0;
    localparam logic [2:0] OFS_STATUS = 3'd1;
    localparam logic [2:0] OFS_CTL    = 3'd2;
    localparam logic [2:0] OFS_EADDR  = 3'd3;

    // control register bit positions
    localparam int CTL_STROBE = 0;
    localparam int CTL_AUTOFD = 1;
    localparam int CTL_INIT   = 2;
    localparam int CTL_DIR    = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CMD,
        ST_STRB,
        ST_DONE,
        ST_ABORT
    } cyc_state_t;

endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= {STAGES{RESET_VAL}};
                end else if (STAGES == 1) begin
                    chain_q[0] <= d;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], d};
                end
            end
            assign q = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/epp_watchdog.sv
module epp_watchdog #(
    parameter int LIMIT = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == LAST);

    // R7
    wd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R7
    wd_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);
endmodule

// File: rtl/epp_decode.sv
module epp_decode
    import epp_pkg::*;
(
    input  logic [2:0] addr,
    output logic       sel_data,
    output logic       sel_status,
    output logic       sel_ctl,
    output logic       sel_eaddr,
    output logic       sel_edata,
    output logic       sel_epp
);
    always_comb begin
        sel_data   = (addr == OFS_DATA);
        sel_status = (addr == OFS_STATUS);
        sel_ctl    = (addr == OFS_CTL);
        sel_eaddr  = (addr == OFS_EADDR);
        sel_edata  = addr[2];
        sel_epp    = sel_eaddr || sel_edata;
    end
endmodule

// File: rtl/epp_host_ctrl.sv
module epp_host_ctrl
    import epp_pkg::*;
#(
    parameter int CLK_HZ      = 200_000_000,
    parameter int TIMEOUT_US  = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       epp_en,
    input  logic       hb_sel,
    input  logic       hb_wr,
    input  logic [2:0] hb_addr,
    input  logic [7:0] hb_wdata,
    output logic [7:0] hb_rdata,
    output logic       hb_stall,
    output logic [7:0] pd_out,
    input  logic [7:0] pd_in,
    output logic       pd_oe,
    output logic       n_write,
    output logic       n_datastb,
    output logic       n_addrstb,
    input  logic       n_wait,
    output logic       strobe_o,
    output logic       autofd_o,
    output logic       init_o
);
    localparam int WD_CYCLES = (CLK_HZ / 1_000_000) * TIMEOUT_US;

    cyc_state_t state_q, state_nx;

    logic       sel_data, sel_status, sel_ctl, sel_eaddr, sel_edata, sel_epp;
    logic       wait_hi;
    logic       wd_run, wd_expired;
    logic       epp_req;
    logic [7:0] ctl_q, data_q, rd_latch_q, cyc_byte_q;
    logic       cyc_addr_q, cyc_wr_q, to_flag_q;
    logic       cyc_drive, host_done, reg_wr;

    epp_decode u_dec (
        .addr       (hb_addr),
        .sel_data   (sel_data),
        .sel_status (sel_status),
        .sel_ctl    (sel_ctl),
        .sel_eaddr  (sel_eaddr),
        .sel_edata  (sel_edata),
        .sel_epp    (sel_epp)
    );

    epp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_wsync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (n_wait),
        .q     (wait_hi)
    );

    assign wd_run = (state_q == ST_SETUP) || (state_q == ST_CMD) || (state_q == ST_STRB);

    epp_watchdog #(.LIMIT(WD_CYCLES)) u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (wd_run),
        .expired (wd_expired)
    );

    assign epp_req   = hb_sel && epp_en && sel_epp;
    assign host_done = (state_q == ST_DONE) || (state_q == ST_ABORT);
    assign reg_wr    = hb_sel && hb_wr && !hb_stall;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (epp_req) state_nx = ST_SETUP;
            ST_SETUP: if (wd_expired) state_nx = ST_ABORT;
                      else if (!wait_hi) state_nx = ST_CMD;
            ST_CMD:   if (wd_expired) state_nx = ST_ABORT;
                      else state_nx = ST_STRB;
            ST_STRB:  if (wait_hi) state_nx = ST_DONE;
                      else if (wd_expired) state_nx = ST_ABORT;
            ST_DONE:  state_nx = ST_IDLE;
            ST_ABORT: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // cycle context latched at start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_addr_q <= 1'b0;
            cyc_wr_q   <= 1'b0;
            cyc_byte_q <= '0;
        end else if (state_q == ST_IDLE && epp_req) begin
            cyc_addr_q <= sel_eaddr;
            cyc_wr_q   <= ctl_q[CTL_STROBE] || (hb_wr && !ctl_q[CTL_DIR]);
            cyc_byte_q <= hb_wr ? hb_wdata : data_q;
        end
    end

    // read byte capture at the end of the strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           rd_latch_q <= '0;
        else if (state_q == ST_STRB && wait_hi) rd_latch_q <= pd_in;
    end

    // host-visible registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            data_q <= '0;
        end else begin
            if (reg_wr && sel_ctl)  ctl_q  <= hb_wdata;
            if (reg_wr && sel_data) data_q <= hb_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                     to_flag_q <= 1'b0;
        else if (state_q == ST_ABORT)                   to_flag_q <= 1'b1;
        else if (reg_wr && sel_status && hb_wdata[0])   to_flag_q <= 1'b0;
    end

    // host side outputs
    always_comb begin
        hb_stall = epp_req && !host_done;
        hb_rdata = 8'hFF;
        if (sel_data)        hb_rdata = ctl_q[CTL_DIR] ? pd_in : data_q;
        else if (sel_status) hb_rdata = {7'b0, to_flag_q};
        else if (sel_ctl)    hb_rdata = ctl_q;
        else if (epp_en && state_q == ST_DONE) hb_rdata = rd_latch_q;
    end

    // peripheral side outputs
    always_comb begin
        cyc_drive = (state_q == ST_CMD) || (state_q == ST_STRB) || (state_q == ST_DONE);
        n_datastb = !(state_q == ST_STRB && !cyc_addr_q);
        n_addrstb = !(state_q == ST_STRB && cyc_addr_q);
        n_write   = !(cyc_drive && cyc_wr_q);
        pd_oe     = cyc_drive ? cyc_wr_q : !ctl_q[CTL_DIR];
        pd_out    = cyc_drive ? cyc_byte_q : data_q;
        strobe_o  = ctl_q[CTL_STROBE];
        autofd_o  = ctl_q[CTL_AUTOFD];
        init_o    = ctl_q[CTL_INIT];
    end

    // R10
    strb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        n_datastb || n_addrstb);

    // R10
    strb_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!n_datastb || !n_addrstb) |-> (hb_sel && hb_stall));

    // R3
    nwrite_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(n_datastb) || $fell(n_addrstb)) |-> $stable(n_write) && $stable(pd_oe));

    // R5
    force_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STRB && ctl_q[CTL_STROBE]) |-> (!n_write && pd_oe));

    // R6
    dir_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STRB && ctl_q[CTL_DIR] && !ctl_q[CTL_STROBE]) |-> (n_write && !pd_oe));

    // R7
    abort_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ABORT) |=> to_flag_q);

    // R7
    abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ABORT) |-> (n_write && n_datastb && n_addrstb && !hb_stall));

    // R9
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!epp_en && state_q == ST_IDLE) |=> state_q == ST_IDLE);
endmodule

// File: tb/epp_host_ctrl_test.sv
module epp_host_ctrl_test;
    localparam int WD = 200 * 10;

    typedef struct packed {
        logic       is_addr;
        logic       drive;
        logic [7:0] byte_v;
        logic       nwr;
    } bus_ev_t;

    logic       clk = 0, rst_n = 0, epp_en = 0;
    logic       hb_sel = 0, hb_wr = 0;
    logic [2:0] hb_addr = 0;
    logic [7:0] hb_wdata = 0, pd_in;
    logic [7:0] hb_rdata, pd_out;
    logic       hb_stall, pd_oe, n_write, n_datastb, n_addrstb, n_wait;
    logic       strobe_o, autofd_o, init_o;

    int checks = 0, fails = 0;
    bit done = 0;
    bit per_on = 1, per_hang = 0;
    logic [7:0] per_byte = 8'h00;
    int cyc;

    bus_ev_t    exp_bus[$];
    logic [7:0] exp_rd[$];
    string      exp_rd_tag[$];
    logic       prev_ds = 1, prev_as = 1;

    always #2.5 clk = ~clk;

    epp_host_ctrl uut (
        .clk(clk), .rst_n(rst_n), .epp_en(epp_en),
        .hb_sel(hb_sel), .hb_wr(hb_wr), .hb_addr(hb_addr), .hb_wdata(hb_wdata),
        .hb_rdata(hb_rdata), .hb_stall(hb_stall),
        .pd_out(pd_out), .pd_in(pd_in), .pd_oe(pd_oe),
        .n_write(n_write), .n_datastb(n_datastb), .n_addrstb(n_addrstb), .n_wait(n_wait),
        .strobe_o(strobe_o), .autofd_o(autofd_o), .init_o(init_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic host_acc(input logic wr, input logic [2:0] a, input logic [7:0] d, output int n);
        @(negedge clk);
        hb_sel = 1; hb_wr = wr; hb_addr = a; hb_wdata = d; n = 0;
        #2;
        while (hb_stall && n < 5000) begin
            @(negedge clk); #2; n++;
        end
        @(posedge clk); #1;
        hb_sel = 0; hb_wr = 0;
    endtask

    task automatic exp_read(input logic [2:0] a, input logic [7:0] v, input string tag, output int n);
        exp_rd.push_back(v); exp_rd_tag.push_back(tag);
        host_acc(1'b0, a, 8'h00, n);
    endtask

    function automatic bus_ev_t ev(input logic ia, input logic dr, input logic [7:0] b, input logic nw);
        bus_ev_t e;
        e.is_addr = ia; e.drive = dr; e.byte_v = b; e.nwr = nw;
        return e;
    endfunction

    // peripheral model
    initial begin
        n_wait = 1; pd_in = 8'h00;
        forever begin
            @(negedge clk); #3;
            if (per_on && hb_sel && hb_stall && n_wait && n_datastb && n_addrstb) begin
                repeat (3) @(negedge clk);
                n_wait = 0;
                while (n_datastb && n_addrstb && hb_stall) @(negedge clk);
                repeat (2) @(negedge clk);
                if (!per_hang) begin
                    pd_in = per_byte;
                    n_wait = 1;
                end
                while (!(n_datastb && n_addrstb)) @(negedge clk);
                n_wait = 1;
            end
        end
    end

    // monitor: strobe events and read completions against the scoreboard
    initial begin
        forever begin
            bus_ev_t e;
            @(negedge clk); #2;
            if (rst_n) begin
                if (!n_datastb && !n_addrstb) check("R10 both strobes low", 1, 0);
                if ((prev_ds && !n_datastb) || (prev_as && !n_addrstb)) begin
                    check("R10 strobe only while stalled", {hb_sel, hb_stall}, 2'b11);
                    check("R3 nWAIT low before strobe", n_wait, 0);
                    if (exp_bus.size() == 0) begin
                        check("R9 unexpected strobe", 1, 0);
                    end else begin
                        e = exp_bus.pop_front();
                        check("R3 strobe select", !n_addrstb, e.is_addr);
                        check("R4/R5/R6 bus direction", pd_oe, e.drive);
                        check("R4/R5/R6 nWRITE level", n_write, e.nwr);
                        if (e.drive) check("R3 driven byte", pd_out, e.byte_v);
                    end
                end
                if (hb_sel && !hb_wr && !hb_stall) begin
                    if (exp_rd.size() == 0) check("scoreboard read underflow", 1, 0);
                    else check(exp_rd_tag.pop_front(), hb_rdata, exp_rd.pop_front());
                end
            end
            prev_ds = n_datastb; prev_as = n_addrstb;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1; rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 n_write", n_write, 1);
        check("R1 n_datastb", n_datastb, 1);
        check("R1 n_addrstb", n_addrstb, 1);
        check("R1 pd_oe", pd_oe, 1);
        exp_read(3'd1, 8'h00, "R1 status reset", cyc);
        exp_read(3'd2, 8'h00, "R1 control reset", cyc);

        // R2 pass-through
        host_acc(1, 3'd2, 8'h07, cyc);
        host_acc(1, 3'd0, 8'hA5, cyc);
        @(negedge clk);
        check("R2 control pins", {strobe_o, autofd_o, init_o}, 3'b111);
        check("R2 pd_out", pd_out, 8'hA5);
        check("R2 pd_oe out", pd_oe, 1);
        host_acc(1, 3'd2, 8'h22, cyc);
        @(negedge clk);
        check("R2 control pins 2", {strobe_o, autofd_o, init_o}, 3'b010);
        check("R2 pd_oe in", pd_oe, 0);
        per_byte = 8'h3E;
        @(negedge clk); pd_in = 8'h3E;
        exp_read(3'd0, 8'h3E, "R2 bidir data read", cyc);
        host_acc(1, 3'd2, 8'h04, cyc);

        // R3 writes
        epp_en = 1;
        exp_bus.push_back(ev(1, 1, 8'h3C, 0));
        host_acc(1, 3'd3, 8'h3C, cyc);
        check("R3 strobes released", {n_datastb, n_addrstb}, 2'b11);
        exp_bus.push_back(ev(0, 1, 8'h91, 0));
        host_acc(1, 3'd4, 8'h91, cyc);
        exp_bus.push_back(ev(0, 1, 8'h6D, 0));
        host_acc(1, 3'd7, 8'h6D, cyc);
        check("R3 write completes", cyc > 3, 1);

        // R4 read
        per_byte = 8'h5A;
        exp_bus.push_back(ev(0, 0, 8'h00, 1));
        exp_read(3'd5, 8'h5A, "R4 read data", cyc);
        per_byte = 8'hC3;
        exp_bus.push_back(ev(1, 0, 8'h00, 1));
        exp_read(3'd3, 8'hC3, "R4 address read", cyc);

        // R5 forced write
        host_acc(1, 3'd2, 8'h05, cyc);
        per_byte = 8'h17;
        exp_bus.push_back(ev(0, 1, 8'hA5, 0));
        exp_read(3'd4, 8'h17, "R5 forced read completes", cyc);

        // R6 direction set turns a write into read-style
        host_acc(1, 3'd2, 8'h24, cyc);
        exp_bus.push_back(ev(0, 0, 8'h00, 1));
        host_acc(1, 3'd6, 8'h11, cyc);
        exp_read(3'd1, 8'h00, "R6 no error flagged", cyc);
        host_acc(1, 3'd2, 8'h04, cyc);

        // R7 timeout with strobe stuck
        per_hang = 1;
        exp_bus.push_back(ev(0, 0, 8'h00, 1));
        exp_read(3'd4, 8'hFF, "R7 aborted read", cyc);
        check("R7 abort window", (cyc >= WD) && (cyc <= WD + 3), 1);
        check("R7 pins released", {n_write, n_datastb, n_addrstb}, 3'b111);
        exp_read(3'd1, 8'h01, "R7 timeout flag", cyc);
        per_hang = 0;
        @(negedge clk); #3;

        // R8 write-one-to-clear
        host_acc(1, 3'd1, 8'hFE, cyc);
        exp_read(3'd1, 8'h01, "R8 flag kept on 0", cyc);
        host_acc(1, 3'd1, 8'h01, cyc);
        exp_read(3'd1, 8'h00, "R8 flag cleared", cyc);

        // R7 timeout with nWAIT never low
        per_on = 0;
        host_acc(1, 3'd4, 8'h42, cyc);
        check("R7 setup abort window", (cyc >= WD) && (cyc <= WD + 3), 1);
        exp_read(3'd1, 8'h01, "R7 setup timeout flag", cyc);
        host_acc(1, 3'd1, 8'h01, cyc);
        per_on = 1;

        // R9 mode off
        epp_en = 0;
        exp_read(3'd5, 8'hFF, "R9 read when off", cyc);
        check("R9 no stall", cyc, 0);
        host_acc(1, 3'd3, 8'h99, cyc);
        check("R9 write no stall", cyc, 0);

        repeat (5) @(negedge clk);
        check("scoreboard bus drained", exp_bus.size(), 0);
        check("scoreboard read drained", exp_rd.size(), 0);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule